// File: doc/BRIEF.md
# Root Port Error Message Status Tracker

This block keeps the status of the error messages that a PCI Express root port receives. It takes one-cycle pulses for correctable, non-fatal and fatal messages. It holds each class as a sticky flag in one 32-bit status word, which software reads through a small register port and clears by writing ones. Only one message of each class is captured. The two "more than one received" positions are therefore tied to zero. The block also records whether the first uncorrectable message since the last clear was fatal, and it reports how many fatal and non-fatal messages have been seen, as one flag each.

A single interrupt request is raised while either pending class is set and the enable input for that class is high. Message decoding, the source-identification register and interrupt message generation stay outside the block. The status word sits at one byte address, set by a parameter. Reads from any other address return zero, and writes to any other address change nothing.

Top module: `errtrk_status`

## Requirements
- R1: Bit 0 (correctable received) sets on a correctable pulse and stays set. A write with data bit 0 = 1 clears it; data bit 0 = 0 leaves it unchanged.
- R2: Bit 2 (uncorrectable received) sets on a non-fatal or a fatal pulse and stays set. A write with data bit 2 = 1 clears it.
- R3: Bits 1 and 3 always read 0, even after writes of 1 to them.
- R4: Bit 4 is 1 when the first uncorrectable message since bit 2 was last clear was fatal. This includes a fatal and a non-fatal pulse in the same cycle. Later messages do not change bit 4.
- R5: Bit 5 sets when a non-fatal message has been received, and bit 6 sets when a fatal message has been received.
- R6: Bits 31:27 read the constant message number (0 by default), and bits 26:7 read 0. Writes to these bits have no effect, and the word resets to 00000000h.
- R7: A write with data bit 2 = 1 clears bits 4, 5 and 6 together with bit 2. The next uncorrectable message then decides bit 4 again.
- R8: When an event pulse and a clearing write hit the same flag in one cycle, the flag ends up set. The uncorrectable group then reflects only that cycle's event.
- R9: `irq` is high exactly while (bit 0 and `irq_en_cor`) or (bit 2 and `irq_en_unc`).
- R10: Writes and reads act only at byte address `REG_ADDR` (130h by default). Other addresses read 0, and writes to them change nothing.
- R11: A pulse or a write changes the status word at the next rising clock edge. A read returns the current word in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_cor | input | 1 | Correctable message pulse |
| ev_nonfatal | input | 1 | Non-fatal message pulse |
| ev_fatal | input | 1 | Fatal message pulse |
| irq_en_cor | input | 1 | Interrupt enable for correctable status |
| irq_en_unc | input | 1 | Interrupt enable for uncorrectable status |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data (ones clear) |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives every pair of consecutive input vectors. Each vector combines the three event pulses, the write strobe, the two clear bits and the two enables. This covers set-versus-clear collisions, simultaneous fatal and non-fatal pulses, and the order in which the first uncorrectable message arrives. All write data carry ones in the reserved and constant-zero positions, so any bit that can be written shows up at once. Directed cases use nearby addresses to show that a mismatched address neither clears nor returns the word. They also repeat each ordering case separately, with its expected value named.

// File: rtl/errtrk_pkg.sv
package errtrk_pkg;

    localparam int WORD_W    = 32;
    localparam int B_COR     = 0;
    localparam int B_MCOR    = 1;
    localparam int B_UNC     = 2;
    localparam int B_MUNC    = 3;
    localparam int B_FIRST   = 4;
    localparam int B_NF      = 5;
    localparam int B_FT      = 6;
    localparam int MSG_LSB   = 27;
    localparam int MSG_W     = 5;

    typedef struct packed {
        logic f_seen;
        logic nf_seen;
        logic first_fatal;
        logic unc;
        logic cor;
    } err_flags_t;

    typedef struct packed {
        logic fatal;
        logic nonfatal;
        logic cor;
    } err_ev_t;

    typedef struct packed {
        logic clr_cor;
        logic clr_unc;
    } err_clr_t;

    function automatic logic [WORD_W-1:0] pack_word(err_flags_t f, logic [MSG_W-1:0] msg);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_COR]   = f.cor;
        w[B_MCOR]  = 1'b0;
        w[B_UNC]   = f.unc;
        w[B_MUNC]  = 1'b0;
        w[B_FIRST] = f.first_fatal;
        w[B_NF]    = f.nf_seen;
        w[B_FT]    = f.f_seen;
        w[MSG_LSB +: MSG_W] = msg;
        return w;
    endfunction

endpackage

// File: rtl/errtrk_wdec.sv
module errtrk_wdec
    import errtrk_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h130
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wdat_cor,
    input  logic              wdat_unc,
    input  logic [ADDR_W-1:0] rd_addr,
    output err_clr_t          clr,
    output logic              rd_hit
);
    logic wr_hit;

    always_comb begin
        wr_hit      = wr_en && (wr_addr == REG_ADDR);
        clr.clr_cor = wr_hit && wdat_cor;
        clr.clr_unc = wr_hit && wdat_unc;
        rd_hit      = (rd_addr == REG_ADDR);
    end
endmodule

// File: rtl/errtrk_flags.sv
module errtrk_flags
    import errtrk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_ev_t    ev,
    input  err_clr_t   clr,
    output err_flags_t flags
);
    err_flags_t base, nxt;
    logic       unc_ev;

    always_comb begin
        unc_ev = ev.fatal | ev.nonfatal;
        base   = flags;
        if (clr.clr_cor) base.cor = 1'b0;
        if (clr.clr_unc) begin
            base.unc         = 1'b0;
            base.first_fatal = 1'b0;
            base.nf_seen     = 1'b0;
            base.f_seen      = 1'b0;
        end
        nxt             = base;
        nxt.cor         = base.cor | ev.cor;
        nxt.unc         = base.unc | unc_ev;
        nxt.nf_seen     = base.nf_seen | ev.nonfatal;
        nxt.f_seen      = base.f_seen | ev.fatal;
        nxt.first_fatal = base.unc ? base.first_fatal : ev.fatal;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    a_r1_cor_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags.cor && !clr.clr_cor) |=> flags.cor);
    a_r8_set_wins_cor: assert property (@(posedge clk) disable iff (rst)
        ev.cor |=> flags.cor);
    a_r2_unc_set: assert property (@(posedge clk) disable iff (rst)
        (ev.fatal || ev.nonfatal) |=> flags.unc);
    a_r7_group_clear: assert property (@(posedge clk) disable iff (rst)
        (clr.clr_unc && !ev.fatal && !ev.nonfatal) |=>
        (!flags.unc && !flags.first_fatal && !flags.nf_seen && !flags.f_seen));
    a_r4_first_stable: assert property (@(posedge clk) disable iff (rst)
        (flags.unc && !clr.clr_unc) |=> $stable(flags.first_fatal));
    a_r4_first_implies_fatal: assert property (@(posedge clk) disable iff (rst)
        flags.first_fatal |-> flags.f_seen);
    a_r5_seen_matches_unc: assert property (@(posedge clk) disable iff (rst)
        flags.unc == (flags.nf_seen || flags.f_seen));
endmodule

// File: rtl/errtrk_irq.sv
module errtrk_irq
    import errtrk_pkg::*;
(
    input  err_flags_t flags,
    input  logic       en_cor,
    input  logic       en_unc,
    output logic       irq
);
    always_comb irq = (flags.cor & en_cor) | (flags.unc & en_unc);
endmodule

// File: rtl/errtrk_status.sv
module errtrk_status
    import errtrk_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h130,
    parameter logic [MSG_W-1:0]  MSG_NUM  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_cor,
    input  logic              ev_nonfatal,
    input  logic              ev_fatal,
    input  logic              irq_en_cor,
    input  logic              irq_en_unc,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq
);
    err_ev_t    ev;
    err_clr_t   clr;
    err_flags_t flags;
    logic       rd_hit;
    logic [WORD_W-1:0] word;

    assign ev = '{fatal: ev_fatal, nonfatal: ev_nonfatal, cor: ev_cor};

    errtrk_wdec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_wdec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wdat_cor (wr_data[B_COR]),
        .wdat_unc (wr_data[B_UNC]),
        .rd_addr  (rd_addr),
        .clr      (clr),
        .rd_hit   (rd_hit)
    );

    errtrk_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .clr   (clr),
        .flags (flags)
    );

    errtrk_irq u_irq (
        .flags  (flags),
        .en_cor (irq_en_cor),
        .en_unc (irq_en_unc),
        .irq    (irq)
    );

    always_comb begin
        word    = pack_word(flags, MSG_NUM);
        rd_data = rd_hit ? word : '0;
    end

    a_r3_multi_zero: assert property (@(posedge clk) disable iff (rst)
        (word[B_MCOR] == 1'b0) && (word[B_MUNC] == 1'b0));
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (word[MSG_LSB-1:B_FT+1] == '0) && (word[MSG_LSB +: MSG_W] == MSG_NUM));
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (word[B_COR] || word[B_UNC]));
    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != REG_ADDR) |-> (rd_data == '0));
endmodule

// File: tb/errtrk_status_test.sv
module errtrk_status_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ev_cor, ev_nonfatal, ev_fatal;
    logic        irq_en_cor, irq_en_unc;
    logic        wr_en;
    logic [11:0] wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq;

    localparam logic [11:0] HOME = 12'h130;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state
    bit m_cor, m_unc, m_first, m_nf, m_f;

    errtrk_status uut (
        .clk(clk), .rst(rst), .ev_cor(ev_cor), .ev_nonfatal(ev_nonfatal),
        .ev_fatal(ev_fatal), .irq_en_cor(irq_en_cor), .irq_en_unc(irq_en_unc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[0] = m_cor; w[2] = m_unc; w[4] = m_first; w[5] = m_nf; w[6] = m_f;
        return w;
    endfunction

    task automatic check_all();
        logic [31:0] e;
        e = exp_word();
        chk("R1 bit0",      {31'd0, rd_data[0]},  {31'd0, e[0]});
        chk("R2 bit2",      {31'd0, rd_data[2]},  {31'd0, e[2]});
        chk("R3 bits1,3",   {30'd0, rd_data[3], rd_data[1]}, 32'd0);
        chk("R4 bit4",      {31'd0, rd_data[4]},  {31'd0, e[4]});
        chk("R5 bits6:5",   {30'd0, rd_data[6:5]}, {30'd0, e[6:5]});
        chk("R6 bits31:7",  {7'd0, rd_data[31:7]}, 32'd0);
        chk("R9 irq",       {31'd0, irq},
            {31'd0, (m_cor & irq_en_cor) | (m_unc & irq_en_unc)});
    endtask

    // one cycle: drive at negedge, model advances, compare after the edge
    task automatic step(input logic [2:0] ev, input bit wr, input bit d0, input bit d2,
                        input logic [1:0] en, input logic [11:0] waddr);
        bit hit, cc, cu, nc, nu, nfirst, nnf, nf;
        ev_cor = ev[0]; ev_nonfatal = ev[1]; ev_fatal = ev[2];
        wr_en = wr; wr_addr = waddr;
        wr_data = 32'hFFFF_FFFA | {29'd0, d2, 1'b0, d0};
        irq_en_cor = en[0]; irq_en_unc = en[1];
        hit = wr && (waddr == HOME);
        cc = hit && d0; cu = hit && d2;
        nc = (m_cor && !cc) || ev[0];
        if (cu) begin m_unc = 0; m_first = 0; m_nf = 0; m_f = 0; end
        nu = m_unc || ev[1] || ev[2];
        nfirst = m_unc ? m_first : ev[2];
        nnf = m_nf || ev[1];
        nf  = m_f || ev[2];
        @(negedge clk);
        m_cor = nc; m_unc = nu; m_first = nfirst; m_nf = nnf; m_f = nf;
        ev_cor = 0; ev_nonfatal = 0; ev_fatal = 0; wr_en = 0;
        check_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ev_cor = 0; ev_nonfatal = 0; ev_fatal = 0; wr_en = 0;
        wr_addr = HOME; wr_data = '0; rd_addr = HOME;
        irq_en_cor = 1; irq_en_unc = 1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_cor = 0; m_unc = 0; m_first = 0; m_nf = 0; m_f = 0;
        chk("R6 reset word", rd_data, 32'h0);
    endtask

    initial begin
        do_reset();
        check_all();

        // pairwise sweep: state-building vector then full vector
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 256; b++) begin
                step(a[2:0], a[3], a[4], a[5], 2'b11, HOME);
                step(b[2:0], b[3], b[4], b[5], b[7:6], HOME);
                step(3'b000, 1'b1, 1'b1, 1'b1, 2'b11, HOME); // clear all
            end
        end

        // R4: nonfatal first, then fatal -> bit4 stays 0
        step(3'b010, 0, 0, 0, 2'b00, HOME);
        step(3'b100, 0, 0, 0, 2'b00, HOME);
        chk("R4 nonfatal-first", {31'd0, rd_data[4]}, 32'd0);
        // R7: clear group, then fatal decides bit4 again
        step(3'b000, 1, 0, 1, 2'b00, HOME);
        chk("R7 group cleared", rd_data & 32'h74, 32'h0);
        step(3'b100, 0, 0, 0, 2'b00, HOME);
        chk("R7 re-decided first", rd_data, 32'h54);
        // R4 simultaneous after clear
        step(3'b000, 1, 0, 1, 2'b00, HOME);
        step(3'b110, 0, 0, 0, 2'b00, HOME);
        chk("R4 simultaneous", rd_data, 32'h74);
        // R8 clear and nonfatal same cycle
        step(3'b010, 1, 1, 1, 2'b00, HOME);
        chk("R8 set wins", rd_data, 32'h24);
        // R1 write of 0 keeps bit0
        step(3'b001, 0, 0, 0, 2'b01, HOME);
        step(3'b000, 1, 0, 0, 2'b01, HOME);
        chk("R1 write0 keeps", {31'd0, rd_data[0]}, 32'd1);
        chk("R9 irq cor", {31'd0, irq}, 32'd1);
        // R10 other addresses: write ignored, read zero
        step(3'b000, 1, 1, 1, 2'b01, 12'h134);
        step(3'b000, 1, 1, 1, 2'b01, 12'h12C);
        chk("R10 miss write ignored", rd_data, 32'h25);
        rd_addr = 12'h134;
        #1;
        chk("R10 miss read zero", rd_data, 32'h0);
        rd_addr = HOME;
        #1;
        chk("R11 read combinational", rd_data, 32'h25);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule